// File: doc/BRIEF.md
# Write-Redirect Way Placement Logic

This block chooses, for one access to one set of a set-associative cache, which way serves the request. The set's ways are split into restricted and free ways by a per-set mask that a wear-levelling controller refreshes every interval. Reads and unrestricted writes are served where the block already sits. A write-back that hits a restricted way is moved to a free way of the same set, so heavily written ways rest for an interval. The copy in the restricted way is then invalidated. Misses are forwarded to the next memory level, and their fill slot is chosen among the free ways.

The decision is formed combinationally from the lookup result, the valid and dirty bits, the recency ages of the set and the restriction mask. All results are presented one clock later as registered outputs. These are a target way, an invalidate strobe for the original copy, a victim write-back strobe, a miss-forward strobe, and a wear-counter increment strobe with its way index. Data storage, recency update and the memory port belong to the surrounding cache.

Top module: `wr_redirect_place`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `dec_valid`, `inval_orig`, `wb_req`, `miss_fwd` and `cnt_inc` are 0, and every way index output is 0.
- R2: A read (`req_write`=0) that hits is served from `hit_way`, even when that way is restricted. It raises no counter, invalidate, write-back or miss strobe.
- R3: A write-back (`req_write`=1) hitting a way whose `restrict_mask` bit is 0 targets `hit_way`. It raises `cnt_inc` with `cnt_way`=`hit_way`, and no invalidate or write-back.
- R4: A write-back hitting a restricted way (mask bit 1) targets the lowest-index way that is both invalid (`valid_bits` bit 0) and unrestricted. No victim write-back is raised in that case.
- R5: If R4 finds no such way, the target is the unrestricted way with the largest age in `lru_age`. Way w's age sits in bits [w*WAY_W +: WAY_W], larger means less recently used, and ties go to the lower index. `wb_req` is raised with `wb_way` equal to the target exactly when that way's dirty bit is 1.
- R6: Every redirection raises `inval_orig` with `inval_way`=`hit_way`, and `cnt_inc` with `cnt_way` equal to the target way.
- R7: When every mask bit is 1, a write-back hit is written in place as in R3 and is not redirected.
- R8: A miss (`hit`=0, read or write) raises `miss_fwd`. Its fill target follows R4 and R5: first free unrestricted way, else the oldest unrestricted way, with `wb_req` if that victim is dirty. A miss raises no `cnt_inc` and no `inval_orig`.
- R9: A miss in a set whose ways are all restricted places the fill by the same rule applied over all ways.
- R10: Outputs reflect the request presented at the previous rising edge. A cycle with `req_valid`=0 yields `dec_valid`=0 and no strobes one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup result is presented this cycle |
| req_write | input | 1 | 1 = write-back from upper level, 0 = read |
| hit | input | 1 | Tag lookup hit |
| hit_way | input | WAY_W | Way that hit |
| valid_bits | input | WAYS | Per-way valid bits of the set |
| dirty_bits | input | WAYS | Per-way dirty bits of the set |
| lru_age | input | WAYS*WAY_W | Per-way recency age, larger is older |
| restrict_mask | input | WAYS | 1 = way is write-restricted this interval |
| dec_valid | output | 1 | Registered decision is valid |
| tgt_way | output | WAY_W | Way that serves the request |
| inval_orig | output | 1 | Invalidate the original copy |
| inval_way | output | WAY_W | Way to invalidate |
| wb_req | output | 1 | Write back the dirty victim |
| wb_way | output | WAY_W | Victim way to write back |
| miss_fwd | output | 1 | Forward the request to next level |
| cnt_inc | output | 1 | Increment a wear counter |
| cnt_way | output | WAY_W | Way whose counter is incremented |

## Verification
The bench targets the edges between the placement paths. These are a read hitting a restricted way, which a careless design would redirect, and an invalid way that is itself restricted, which a wrong scan would pick ahead of a valid free way. A fully restricted set must not produce a redirect with no legal target. The bench also checks victim choice under two opposite age orders: a design that picked by index rather than age, or looked at restricted ways, lands on the wrong way. It also checks write-backs raised for clean victims, counters bumped on misses or reads, and strobes leaking out of idle cycles or reset.

// File: rtl/wr_pkg.sv
package wr_pkg;

    typedef enum logic [2:0] {
        ACT_IDLE     = 3'd0,
        ACT_READ     = 3'd1,
        ACT_INPLACE  = 3'd2,
        ACT_REDIRECT = 3'd3,
        ACT_FILL     = 3'd4
    } act_e;

    typedef struct packed {
        logic inval;
        logic wb;
        logic miss;
        logic cnt;
    } strobe_t;

    localparam strobe_t STROBE_NONE = '{inval: 1'b0, wb: 1'b0, miss: 1'b0, cnt: 1'b0};

    function automatic logic all_set(input logic [63:0] bits, input int n);
        logic r;
        r = 1'b1;
        for (int i = 0; i < 64; i++) begin
            if (i < n && !bits[i]) r = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/wr_first_free.sv
module wr_first_free #(
    parameter int WAYS  = 8,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (cand[w]) begin
                found = 1'b1;
                idx   = IDX_W'(w);
            end
        end
    end
endmodule

// File: rtl/wr_oldest_pick.sv
module wr_oldest_pick #(
    parameter int WAYS  = 8,
    parameter int AGE_W = $clog2(WAYS),
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS*AGE_W-1:0] ages,
    input  logic [WAYS-1:0]       eligible,
    output logic                  found,
    output logic [IDX_W-1:0]      idx
);
    logic [AGE_W-1:0] age_arr [WAYS];

    for (genvar g = 0; g < WAYS; g++) begin : g_unpack
        assign age_arr[g] = ages[g*AGE_W +: AGE_W];
    end

    always_comb begin
        logic [AGE_W-1:0] best;
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (eligible[w] && (!found || age_arr[w] > best)) begin
                found = 1'b1;
                idx   = IDX_W'(w);
                best  = age_arr[w];
            end
        end
    end
endmodule

// File: rtl/wr_place_decide.sv
module wr_place_decide
    import wr_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  hit,
    input  logic [WAY_W-1:0]      hit_way,
    input  logic [WAYS-1:0]       valid_bits,
    input  logic [WAYS-1:0]       dirty_bits,
    input  logic [WAYS*WAY_W-1:0] lru_age,
    input  logic [WAYS-1:0]       restrict_mask,
    output act_e                  act,
    output logic [WAY_W-1:0]      tgt,
    output strobe_t               strb
);
    localparam logic [WAYS-1:0] ALL_ONES = '1;

    logic             all_restr;
    logic             hit_restr;
    logic [WAYS-1:0]  free_nr;
    logic [WAYS-1:0]  free_any;
    logic [WAYS-1:0]  elig_nr;

    logic             ff_nr_found,  ff_all_found;
    logic [WAY_W-1:0] ff_nr_idx,    ff_all_idx;
    logic             old_nr_found, old_all_found;
    logic [WAY_W-1:0] old_nr_idx,   old_all_idx;

    logic             place_free;
    logic [WAY_W-1:0] place_way;

    assign all_restr = (restrict_mask == ALL_ONES);
    assign hit_restr = restrict_mask[hit_way];
    assign elig_nr   = ~restrict_mask;
    assign free_nr   = ~valid_bits & ~restrict_mask;
    assign free_any  = ~valid_bits;

    wr_first_free #(.WAYS(WAYS), .IDX_W(WAY_W)) u_ff_nr (
        .cand(free_nr), .found(ff_nr_found), .idx(ff_nr_idx)
    );
    wr_first_free #(.WAYS(WAYS), .IDX_W(WAY_W)) u_ff_all (
        .cand(free_any), .found(ff_all_found), .idx(ff_all_idx)
    );
    wr_oldest_pick #(.WAYS(WAYS), .AGE_W(WAY_W), .IDX_W(WAY_W)) u_old_nr (
        .ages(lru_age), .eligible(elig_nr), .found(old_nr_found), .idx(old_nr_idx)
    );
    wr_oldest_pick #(.WAYS(WAYS), .AGE_W(WAY_W), .IDX_W(WAY_W)) u_old_all (
        .ages(lru_age), .eligible(ALL_ONES), .found(old_all_found), .idx(old_all_idx)
    );

    // Placement slot: a free slot first, else the oldest candidate.
    always_comb begin
        if (all_restr) begin
            place_free = ff_all_found;
            place_way  = ff_all_found ? ff_all_idx : old_all_idx;
        end else if (ff_nr_found) begin
            place_free = 1'b1;
            place_way  = ff_nr_idx;
        end else begin
            place_free = 1'b0;
            place_way  = old_nr_found ? old_nr_idx : old_all_idx;
        end
    end

    always_comb begin
        act  = ACT_IDLE;
        tgt  = '0;
        strb = STROBE_NONE;
        if (req_valid) begin
            if (!hit) begin
                act       = ACT_FILL;
                tgt       = place_way;
                strb.miss = 1'b1;
                strb.wb   = !place_free && dirty_bits[place_way];
            end else if (!req_write) begin
                act = ACT_READ;
                tgt = hit_way;
            end else if (!hit_restr || all_restr) begin
                act      = ACT_INPLACE;
                tgt      = hit_way;
                strb.cnt = 1'b1;
            end else begin
                act        = ACT_REDIRECT;
                tgt        = place_way;
                strb.inval = 1'b1;
                strb.cnt   = 1'b1;
                strb.wb    = !place_free && dirty_bits[place_way];
            end
        end
    end
endmodule

// File: rtl/wr_redirect_place.sv
module wr_redirect_place
    import wr_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  hit,
    input  logic [WAY_W-1:0]      hit_way,
    input  logic [WAYS-1:0]       valid_bits,
    input  logic [WAYS-1:0]       dirty_bits,
    input  logic [WAYS*WAY_W-1:0] lru_age,
    input  logic [WAYS-1:0]       restrict_mask,
    output logic                  dec_valid,
    output logic [WAY_W-1:0]      tgt_way,
    output logic                  inval_orig,
    output logic [WAY_W-1:0]      inval_way,
    output logic                  wb_req,
    output logic [WAY_W-1:0]      wb_way,
    output logic                  miss_fwd,
    output logic                  cnt_inc,
    output logic [WAY_W-1:0]      cnt_way
);
    act_e             nxt_act;
    logic [WAY_W-1:0] nxt_tgt;
    strobe_t          nxt_strb;

    wr_place_decide #(.WAYS(WAYS), .WAY_W(WAY_W)) u_decide (
        .req_valid     (req_valid),
        .req_write     (req_write),
        .hit           (hit),
        .hit_way       (hit_way),
        .valid_bits    (valid_bits),
        .dirty_bits    (dirty_bits),
        .lru_age       (lru_age),
        .restrict_mask (restrict_mask),
        .act           (nxt_act),
        .tgt           (nxt_tgt),
        .strb          (nxt_strb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            tgt_way    <= '0;
            inval_orig <= 1'b0;
            inval_way  <= '0;
            wb_req     <= 1'b0;
            wb_way     <= '0;
            miss_fwd   <= 1'b0;
            cnt_inc    <= 1'b0;
            cnt_way    <= '0;
        end else begin
            dec_valid  <= (nxt_act != ACT_IDLE);
            tgt_way    <= nxt_tgt;
            inval_orig <= nxt_strb.inval;
            inval_way  <= nxt_strb.inval ? hit_way : '0;
            wb_req     <= nxt_strb.wb;
            wb_way     <= nxt_strb.wb ? nxt_tgt : '0;
            miss_fwd   <= nxt_strb.miss;
            cnt_inc    <= nxt_strb.cnt;
            cnt_way    <= nxt_strb.cnt ? nxt_tgt : '0;
        end
    end
endmodule

// File: rtl/wr_redirect_place_chk.sv
module wr_redirect_place_chk #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_write,
    input logic                  hit,
    input logic [WAY_W-1:0]      hit_way,
    input logic [WAYS-1:0]       valid_bits,
    input logic [WAYS-1:0]       dirty_bits,
    input logic [WAYS*WAY_W-1:0] lru_age,
    input logic [WAYS-1:0]       restrict_mask,
    input logic                  dec_valid,
    input logic [WAY_W-1:0]      tgt_way,
    input logic                  inval_orig,
    input logic [WAY_W-1:0]      inval_way,
    input logic                  wb_req,
    input logic [WAY_W-1:0]      wb_way,
    input logic                  miss_fwd,
    input logic                  cnt_inc,
    input logic [WAY_W-1:0]      cnt_way
);
    logic             p_write, p_hit;
    logic [WAY_W-1:0] p_hit_way;
    logic [WAYS-1:0]  p_valid, p_dirty, p_mask;
    logic             p_all_restr;

    always_ff @(posedge clk) begin
        p_write   <= req_write;
        p_hit     <= hit;
        p_hit_way <= hit_way;
        p_valid   <= valid_bits;
        p_dirty   <= dirty_bits;
        p_mask    <= restrict_mask;
    end
    assign p_all_restr = &p_mask;

    a_r2_read_hit_in_place: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !p_write && p_hit |->
            tgt_way == p_hit_way && !cnt_inc && !inval_orig && !wb_req && !miss_fwd);

    a_r3_write_unrestricted_in_place: assert property (@(posedge clk) disable iff (rst)
        dec_valid && p_write && p_hit && !p_mask[p_hit_way] |->
            tgt_way == p_hit_way && cnt_inc && cnt_way == p_hit_way && !inval_orig);

    a_r4_redirect_to_unrestricted: assert property (@(posedge clk) disable iff (rst)
        inval_orig |-> !p_mask[tgt_way]);

    a_r5_writeback_only_dirty: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> p_dirty[wb_way] && p_valid[wb_way] && wb_way == tgt_way);

    a_r6_redirect_bookkeeping: assert property (@(posedge clk) disable iff (rst)
        inval_orig |-> inval_way == p_hit_way && cnt_inc && cnt_way == tgt_way
                       && tgt_way != p_hit_way);

    a_r7_full_mask_no_redirect: assert property (@(posedge clk) disable iff (rst)
        dec_valid && p_hit && p_write && p_all_restr |-> !inval_orig && tgt_way == p_hit_way);

    a_r8_miss_forward: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> miss_fwd == !p_hit);

    a_r8_fill_unrestricted: assert property (@(posedge clk) disable iff (rst)
        miss_fwd && !p_all_restr |-> !p_mask[tgt_way] && !cnt_inc && !inval_orig);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !cnt_inc && !wb_req && !miss_fwd && !inval_orig);
endmodule

bind wr_redirect_place wr_redirect_place_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (.*);

// File: tb/wr_redirect_place_test.sv
module wr_redirect_place_test;
    localparam int WAYS  = 8;
    localparam int WAY_W = 3;
    localparam int NV    = 14;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  req_valid, req_write, hit;
    logic [WAY_W-1:0]      hit_way;
    logic [WAYS-1:0]       valid_bits, dirty_bits, restrict_mask;
    logic [WAYS*WAY_W-1:0] lru_age;
    logic                  dec_valid, inval_orig, wb_req, miss_fwd, cnt_inc;
    logic [WAY_W-1:0]      tgt_way, inval_way, wb_way, cnt_way;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wr_redirect_place #(.WAYS(WAYS), .WAY_W(WAY_W)) uut (.*);

    // Vector: {wr, hit, hit_way[3], valid[8], dirty[8], mask[8], agesel,
    //          exp_tgt[3], exp_inval, exp_wb, exp_miss, exp_cnt}
    // agesel 0: age of way w = w (way 7 oldest); 1: age = 7-w (way 0 oldest)
    localparam logic [36:0] VEC [NV] = '{
        {1'b0,1'b1,3'd2,8'hFF,8'h00,8'h00,1'b0, 3'd2,1'b0,1'b0,1'b0,1'b0}, // R2
        {1'b0,1'b1,3'd5,8'hFF,8'hFF,8'h22,1'b0, 3'd5,1'b0,1'b0,1'b0,1'b0}, // R2 restricted read
        {1'b1,1'b1,3'd7,8'hFF,8'h00,8'h22,1'b0, 3'd7,1'b0,1'b0,1'b0,1'b1}, // R3
        {1'b1,1'b1,3'd5,8'hF7,8'hFF,8'h22,1'b0, 3'd3,1'b1,1'b0,1'b0,1'b1}, // R4 R6
        {1'b1,1'b1,3'd5,8'h56,8'hFF,8'h22,1'b0, 3'd0,1'b1,1'b0,1'b0,1'b1}, // R4 lowest
        {1'b1,1'b1,3'd1,8'hFF,8'h80,8'h22,1'b0, 3'd7,1'b1,1'b1,1'b0,1'b1}, // R5 dirty
        {1'b1,1'b1,3'd1,8'hFF,8'h80,8'h22,1'b1, 3'd0,1'b1,1'b0,1'b0,1'b1}, // R5 clean
        {1'b1,1'b1,3'd1,8'hFF,8'h04,8'h03,1'b1, 3'd2,1'b1,1'b1,1'b0,1'b1}, // R5 skip restr
        {1'b1,1'b1,3'd4,8'hFF,8'hFF,8'hFF,1'b0, 3'd4,1'b0,1'b0,1'b0,1'b1}, // R7
        {1'b0,1'b0,3'd0,8'hEF,8'h00,8'h10,1'b0, 3'd7,1'b0,1'b0,1'b1,1'b0}, // R8 restr free
        {1'b1,1'b0,3'd0,8'h7F,8'hFF,8'h00,1'b0, 3'd7,1'b0,1'b0,1'b1,1'b0}, // R8 free
        {1'b0,1'b0,3'd0,8'hFF,8'h80,8'h00,1'b0, 3'd7,1'b0,1'b1,1'b1,1'b0}, // R8 victim
        {1'b0,1'b0,3'd0,8'hFB,8'h00,8'hFF,1'b0, 3'd2,1'b0,1'b0,1'b1,1'b0}, // R9 free
        {1'b1,1'b0,3'd0,8'hFF,8'h01,8'hFF,1'b1, 3'd0,1'b0,1'b1,1'b1,1'b0}  // R9 victim
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1:       return "R2";
            2:          return "R3";
            3, 4:       return "R4";
            5, 6, 7:    return "R5";
            8:          return "R7";
            9, 10, 11:  return "R8";
            default:    return "R9";
        endcase
    endfunction

    function automatic logic [WAYS*WAY_W-1:0] ages(input logic sel);
        logic [WAYS*WAY_W-1:0] a;
        for (int w = 0; w < WAYS; w++)
            a[w*WAY_W +: WAY_W] = sel ? WAY_W'(WAYS - 1 - w) : WAY_W'(w);
        return a;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; req_write = 0; hit = 0; hit_way = '0;
        valid_bits = '0; dirty_bits = '0; restrict_mask = '0; lru_age = ages(1'b0);
    endtask

    task automatic check_quiet(input string tag);
        check(tag, "dec_valid", dec_valid, 0);
        check(tag, "strobes", {inval_orig, wb_req, miss_fwd, cnt_inc}, 0);
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "dec_valid", dec_valid, 0);
        check("R1", "strobes", {inval_orig, wb_req, miss_fwd, cnt_inc}, 0);
        check("R1", "ways", {tgt_way, inval_way, wb_way, cnt_way}, 0);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            logic [36:0] v;
            v = VEC[i];
            @(negedge clk);
            req_valid = 1; req_write = v[36]; hit = v[35]; hit_way = v[34:32];
            valid_bits = v[31:24]; dirty_bits = v[23:16]; restrict_mask = v[15:8];
            lru_age = ages(v[7]);
            @(negedge clk);
            check(tag_of(i), "dec_valid", dec_valid, 1);
            check(tag_of(i), "tgt_way", tgt_way, v[6:4]);
            check(tag_of(i), "inval", {inval_orig, inval_way}, v[3] ? {1'b1, v[34:32]} : 4'd0);
            check(tag_of(i), "wb", {wb_req, wb_way}, v[2] ? {1'b1, v[6:4]} : 4'd0);
            check(tag_of(i), "miss_fwd", miss_fwd, v[1]);
            check(tag_of(i), "cnt", {cnt_inc, cnt_way}, v[0] ? {1'b1, v[6:4]} : 4'd0);
        end

        // R10: a request with req_valid low produces nothing one cycle later
        @(negedge clk);
        idle_inputs();
        req_write = 1; hit = 0; valid_bits = 8'hFF; dirty_bits = 8'hFF;
        @(negedge clk);
        check_quiet("R10");

        // R10: result appears exactly one cycle after the request, then clears
        req_valid = 1; req_write = 1; hit = 1; hit_way = 3'd6;
        valid_bits = 8'hFF; dirty_bits = 8'h00; restrict_mask = 8'h00;
        #5;
        check("R10", "no early output", dec_valid, 0);
        @(negedge clk);
        check("R10", "cnt one cycle later", {cnt_inc, cnt_way}, {1'b1, 3'd6});
        idle_inputs();
        @(negedge clk);
        check_quiet("R10");

        // R1: reset during a live redirect request suppresses all outputs
        req_valid = 1; req_write = 1; hit = 1; hit_way = 3'd1;
        valid_bits = 8'hFF; dirty_bits = 8'hFF; restrict_mask = 8'h02;
        rst = 1;
        @(negedge clk);
        check_quiet("R1");
        rst = 0;
        @(negedge clk);
        // first cycle after reset reflects the request held across the release edge
        check("R6", "post-reset redirect", {inval_orig, inval_way}, {1'b1, 3'd1});
        check("R5", "post-reset victim", {wb_req, wb_way}, {1'b1, 3'd7});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule